// File: doc/BRIEF.md
# Serial Expansion Channel Controller

This block is the register-mapped front end of one serial expansion channel. Software programs a status word (interrupt flags with their enables, a serial clock rate and a one-hot device select), a command word, a 32-bit immediate data word, and a pair of block-transfer address and length words. Setting the go bit in the command word starts an operation. In immediate mode the controller runs a serial exchange of 1 to 4 bytes on a mode-0 serial bus. The exchange can be receive-only, send-only or full duplex. When it finishes, the go bit drops and a completion flag is raised.

The same RTL serves every channel of a multi-channel unit. The `CHAN_ID` parameter removes features a channel does not carry. The attach-event interrupt exists only on channels 0 and 1, and the boot-memory disable bit only on channel 0. Block-transfer commands are accepted and complete at once, because moving memory belongs to another block. Their address and length words are held for that block to use.

Top module: `sxc_channel`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0, `sclk_o` is 0 and all bits of `cs_n_o` are 1.
- R2: Status bits 0, 2 and 4 are the device, completion and attach flags; bits 1, 3 and 5 are their enables. Writing 1 to a flag bit clears it, writing 0 leaves it, enable bits take the written value; a set event in the same cycle as a clearing write leaves the flag at 1.
- R3: `irq_o` is 1 exactly when some flag and its enable are both 1.
- R4: The attach flag is set by a `presence_i` pulse on channels 0 and 1; on channel 2 status bits 4 and 5 always read 0.
- R5: Status bit 12 drives `rom_dis_o` and is writable only on channel 0; elsewhere it reads 0.
- R6: Status bits 11:9 are the device select, driven inverted on `cs_n_o`. A write holding more than one set select bit leaves the field unchanged while its other fields still apply; an accepted write pulses `cs_chg_o` with old XOR new select for the one cycle after the write.
- R7: Command word: bit 0 go, bit 1 block mode, bits 3:2 direction (0 receive, 1 send, 2 duplex, 3 reserved), bits 5:4 byte count minus one. An accepted go bit reads 1 until completion; completion clears it and sets the completion flag.
- R8: The serial clock idles low with a period of 2^(n+1) clock cycles, where n is status bits 8:6. Data leaves MSB first, changes after falling edges and is sampled on rising edges. An immediate exchange of b bytes ends 16·b·2^n cycles after the command write.
- R9: Send mode leaves the immediate word unchanged; receive mode drives `mosi_o` low; receive and duplex replace the top b bytes of the immediate word with the received bytes and keep its lower bytes.
- R10: A block-mode command with send or receive direction completes in the next cycle. Duplex in block mode, or the reserved direction in either mode, leaves go at 0 and raises no flag.
- R11: The block address and length words store the written value with their low 5 bits forced to 0.
- R12: While go reads 1, writes to the command and immediate words are ignored.
- R13: `dev_irq_i` held high sets the device flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | word index: 0 status, 1 block address, 2 block length, 3 command, 4 immediate |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for `reg_addr`, combinational |
| dev_irq_i | input | 1 | device interrupt request |
| presence_i | input | 1 | device attach/detach event pulse |
| irq_o | output | 1 | channel interrupt |
| rom_dis_o | output | 1 | boot-memory disable |
| cs_n_o | output | 3 | active-low device selects |
| cs_chg_o | output | 3 | one-cycle notification of selects that changed |
| sclk_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| miso_i | input | 1 | serial data in |

## Verification
The assertions assume that every register write is a single-cycle strobe and that `presence_i` and `dev_irq_i` change only between clock edges. They also assume that `miso_i` is stable around each rising serial clock edge. The stimulus drives all inputs on the falling system clock edge. The bench device model changes `miso_i` only on a falling serial clock edge, and it preloads the first bit before the go write, so the sampling window is always respected.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
    localparam int DATA_W = 32;
    localparam int CLK_W  = 3;
    localparam int NUM_CS = 3;
    localparam int LEN_W  = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_DADR = 3'd1;
    localparam logic [ADDR_W-1:0] A_DLEN = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] A_IMM  = 3'd4;

    localparam int S_DEVF = 0;
    localparam int S_DEVM = 1;
    localparam int S_TCF  = 2;
    localparam int S_TCM  = 3;
    localparam int S_EXTF = 4;
    localparam int S_EXTM = 5;
    localparam int S_CLK  = 6;
    localparam int S_CS   = S_CLK + CLK_W;
    localparam int S_ROM  = S_CS + NUM_CS;

    localparam int C_START = 0;
    localparam int C_DMA   = 1;
    localparam int C_DIR   = 2;
    localparam int C_LEN   = 4;

    typedef enum logic [1:0] {
        DIR_RD   = 2'd0,
        DIR_WR   = 2'd1,
        DIR_XCHG = 2'd2,
        DIR_RSVD = 2'd3
    } sxc_dir_e;

    typedef struct packed {
        logic              dev_f;
        logic              dev_m;
        logic              tc_f;
        logic              tc_m;
        logic              ext_f;
        logic              ext_m;
        logic [CLK_W-1:0]  clk;
        logic [NUM_CS-1:0] cs;
        logic              rom;
    } sxc_stat_t;

    typedef struct packed {
        logic             start;
        logic             dma;
        sxc_dir_e         dir;
        logic [LEN_W-1:0] len;
    } sxc_ctrl_t;
endpackage

// File: rtl/sxc_shifter.sv
module sxc_shifter
    import sxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  sxc_dir_e          dir_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [CLK_W-1:0]  clk_sel_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              wb_o,
    output logic [DATA_W-1:0] merged_o
);
    localparam int DIV_W = 1 << CLK_W;
    localparam int BIT_W = $clog2(DATA_W);
    localparam int SH_W  = BIT_W + 1;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic [DIV_W-1:0]  div;
        logic [DIV_W-1:0]  half_m1;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [LEN_W-1:0]  len;
        sxc_dir_e          dir;
    } sh_t;

    sh_t q, n;
    logic [BIT_W-1:0] last_bit;
    logic [SH_W-1:0]  nbits;
    logic [SH_W-1:0]  shamt;

    assign last_bit = {q.len, 3'b111};
    assign nbits    = SH_W'({1'b0, q.len} + 1'b1) << 3;
    assign shamt    = SH_W'(DATA_W) - nbits;

    always_comb begin
        n      = q;
        done_o = 1'b0;
        if (launch_i) begin
            n.busy    = 1'b1;
            n.sclk    = 1'b0;
            n.div     = '0;
            n.bitn    = '0;
            n.tx      = imm_i;
            n.rx      = '0;
            n.len     = len_i;
            n.dir     = dir_i;
            n.half_m1 = (DIV_W'(1) << clk_sel_i) - DIV_W'(1);
        end else if (q.busy) begin
            if (q.div == q.half_m1) begin
                n.div = '0;
                if (!q.sclk) begin
                    n.sclk = 1'b1;
                    n.rx   = {q.rx[DATA_W-2:0], miso_i};
                end else begin
                    n.sclk = 1'b0;
                    n.tx   = q.tx << 1;
                    if (q.bitn == last_bit) begin
                        n.busy = 1'b0;
                        done_o = 1'b1;
                    end else begin
                        n.bitn = q.bitn + 1'b1;
                    end
                end
            end else begin
                n.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sclk_o   = q.sclk;
    assign busy_o   = q.busy;
    assign mosi_o   = q.busy && (q.dir != DIR_RD) && q.tx[DATA_W-1];
    assign wb_o     = done_o && (q.dir != DIR_WR);
    assign merged_o = (q.rx << shamt) | (imm_i & ~({DATA_W{1'b1}} << shamt));
endmodule

// File: rtl/sxc_regs.sv
module sxc_regs
    import sxc_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int ALIGN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_irq_i,
    input  logic              presence_i,
    input  logic              sh_done_i,
    input  logic              sh_wb_i,
    input  logic [DATA_W-1:0] sh_merged_i,
    output logic              launch_o,
    output sxc_dir_e          l_dir_o,
    output logic [LEN_W-1:0]  l_len_o,
    output logic [CLK_W-1:0]  clk_sel_o,
    output logic [DATA_W-1:0] imm_o,
    output logic              xfer_done_o,
    output logic              irq_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic [NUM_CS-1:0] cs_chg_o,
    output logic              rom_dis_o
);
    localparam bit HAS_EXT = (CHAN_ID != 2);
    localparam bit HAS_ROM = (CHAN_ID == 0);
    localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << ALIGN;

    typedef struct packed {
        sxc_stat_t         st;
        sxc_ctrl_t         ct;
        logic [DATA_W-1:0] dadr;
        logic [DATA_W-1:0] dlen;
        logic [DATA_W-1:0] imm;
        logic [NUM_CS-1:0] chg;
    } regs_t;

    regs_t q, n;
    logic [NUM_CS-1:0] cs_new;
    sxc_dir_e          w_dir;
    logic              w_dma;
    logic              dir_ok;

    assign cs_new = reg_wdata[S_CS +: NUM_CS];
    assign w_dir  = sxc_dir_e'(reg_wdata[C_DIR +: 2]);
    assign w_dma  = reg_wdata[C_DMA];
    assign dir_ok = (w_dir == DIR_RD) || (w_dir == DIR_WR) ||
                    ((w_dir == DIR_XCHG) && !w_dma);

    always_comb begin
        n           = q;
        n.chg       = '0;
        launch_o    = 1'b0;
        xfer_done_o = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_STAT: begin
                    n.st.dev_m = reg_wdata[S_DEVM];
                    if (reg_wdata[S_DEVF]) n.st.dev_f = 1'b0;
                    n.st.tc_m = reg_wdata[S_TCM];
                    if (reg_wdata[S_TCF]) n.st.tc_f = 1'b0;
                    if (HAS_EXT) begin
                        n.st.ext_m = reg_wdata[S_EXTM];
                        if (reg_wdata[S_EXTF]) n.st.ext_f = 1'b0;
                    end
                    n.st.clk = reg_wdata[S_CLK +: CLK_W];
                    if ($onehot0(cs_new)) begin
                        n.st.cs = cs_new;
                        n.chg   = q.st.cs ^ cs_new;
                    end
                    if (HAS_ROM) n.st.rom = reg_wdata[S_ROM];
                end
                A_DADR: n.dadr = reg_wdata & KEEP_MASK;
                A_DLEN: n.dlen = reg_wdata & KEEP_MASK;
                A_CTRL: begin
                    if (!q.ct.start) begin
                        n.ct.dma   = w_dma;
                        n.ct.dir   = w_dir;
                        n.ct.len   = reg_wdata[C_LEN +: LEN_W];
                        n.ct.start = reg_wdata[C_START] && dir_ok;
                        launch_o   = n.ct.start && !w_dma;
                    end
                end
                A_IMM: begin
                    if (!q.ct.start) n.imm = reg_wdata;
                end
                default: ;
            endcase
        end
        if (q.ct.start && (q.ct.dma || sh_done_i)) begin
            n.ct.start  = 1'b0;
            n.st.tc_f   = 1'b1;
            xfer_done_o = 1'b1;
        end
        if (sh_wb_i) n.imm = sh_merged_i;
        if (dev_irq_i) n.st.dev_f = 1'b1;
        if (HAS_EXT && presence_i) n.st.ext_f = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT: begin
                reg_rdata[S_DEVF]            = q.st.dev_f;
                reg_rdata[S_DEVM]            = q.st.dev_m;
                reg_rdata[S_TCF]             = q.st.tc_f;
                reg_rdata[S_TCM]             = q.st.tc_m;
                reg_rdata[S_EXTF]            = q.st.ext_f;
                reg_rdata[S_EXTM]            = q.st.ext_m;
                reg_rdata[S_CLK +: CLK_W]    = q.st.clk;
                reg_rdata[S_CS +: NUM_CS]    = q.st.cs;
                reg_rdata[S_ROM]             = q.st.rom;
            end
            A_DADR: reg_rdata = q.dadr;
            A_DLEN: reg_rdata = q.dlen;
            A_CTRL: begin
                reg_rdata[C_START]          = q.ct.start;
                reg_rdata[C_DMA]            = q.ct.dma;
                reg_rdata[C_DIR +: 2]       = q.ct.dir;
                reg_rdata[C_LEN +: LEN_W]   = q.ct.len;
            end
            A_IMM:  reg_rdata = q.imm;
            default: ;
        endcase
    end

    assign l_dir_o   = w_dir;
    assign l_len_o   = reg_wdata[C_LEN +: LEN_W];
    assign clk_sel_o = q.st.clk;
    assign imm_o     = q.imm;
    assign irq_o     = (q.st.dev_f & q.st.dev_m) | (q.st.tc_f & q.st.tc_m) |
                       (q.st.ext_f & q.st.ext_m);
    assign cs_n_o    = ~q.st.cs;
    assign cs_chg_o  = q.chg;
    assign rom_dis_o = q.st.rom;
endmodule

// File: rtl/sxc_channel.sv
module sxc_channel
    import sxc_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int ALIGN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_irq_i,
    input  logic              presence_i,
    output logic              irq_o,
    output logic              rom_dis_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic [NUM_CS-1:0] cs_chg_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    logic              launch;
    sxc_dir_e          l_dir;
    logic [LEN_W-1:0]  l_len;
    logic [CLK_W-1:0]  clk_sel;
    logic [DATA_W-1:0] imm;
    logic              sh_busy;
    logic              sh_done;
    logic              sh_wb;
    logic [DATA_W-1:0] sh_merged;
    logic              xfer_done;

    sxc_regs #(.CHAN_ID(CHAN_ID), .ALIGN(ALIGN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dev_irq_i  (dev_irq_i),
        .presence_i (presence_i),
        .sh_done_i  (sh_done),
        .sh_wb_i    (sh_wb),
        .sh_merged_i(sh_merged),
        .launch_o   (launch),
        .l_dir_o    (l_dir),
        .l_len_o    (l_len),
        .clk_sel_o  (clk_sel),
        .imm_o      (imm),
        .xfer_done_o(xfer_done),
        .irq_o      (irq_o),
        .cs_n_o     (cs_n_o),
        .cs_chg_o   (cs_chg_o),
        .rom_dis_o  (rom_dis_o)
    );

    sxc_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .dir_i    (l_dir),
        .len_i    (l_len),
        .clk_sel_i(clk_sel),
        .imm_i    (imm),
        .miso_i   (miso_i),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .busy_o   (sh_busy),
        .done_o   (sh_done),
        .wb_o     (sh_wb),
        .merged_o (sh_merged)
    );
endmodule

// File: rtl/sxc_channel_chk.sv
module sxc_channel_chk
    import sxc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              dev_irq_i,
    input logic              presence_i,
    input logic              irq_o,
    input logic [NUM_CS-1:0] cs_n_o,
    input logic [NUM_CS-1:0] cs_chg_o,
    input logic              sclk_o,
    input logic              mosi_o,
    input logic              busy,
    input logic              done
);
    // R3
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(dev_irq_i || presence_i || reg_wr || done));

    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk_o);

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R6
    cs_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_chg_o != '0) |-> $past(reg_wr && (reg_addr == A_STAT)));

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

bind sxc_channel sxc_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .dev_irq_i (dev_irq_i),
    .presence_i(presence_i),
    .irq_o     (irq_o),
    .cs_n_o    (cs_n_o),
    .cs_chg_o  (cs_chg_o),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .busy      (sh_busy),
    .done      (xfer_done)
);

// File: tb/sxc_channel_bench.sv
`timescale 1ns/1ps
module sxc_channel_bench;
    import sxc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        dev_irq = 1'b0;
    logic        pres = 1'b0;
    logic        miso;
    logic [31:0] rdata0, rdata2;
    logic        irq0, irq2, rom0, rom2, sclk0, sclk2, mosi0, mosi2;
    logic [2:0]  csn0, csn2, chg0, chg2;
    logic [31:0] s_tx = '0;
    logic [31:0] s_rx = '0;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;
    assign miso = s_tx[31];

    always @(posedge sclk0) s_rx <= {s_rx[30:0], mosi0};
    always @(negedge sclk0) s_tx <= s_tx << 1;

    sxc_channel #(.CHAN_ID(0)) u_sxc_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0), .dev_irq_i(dev_irq),
        .presence_i(pres), .irq_o(irq0), .rom_dis_o(rom0), .cs_n_o(csn0),
        .cs_chg_o(chg0), .sclk_o(sclk0), .mosi_o(mosi0), .miso_i(miso));

    sxc_channel #(.CHAN_ID(2)) u_sxc_channel_c2 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata2), .dev_irq_i(dev_irq),
        .presence_i(pres), .irq_o(irq2), .rom_dis_o(rom2), .cs_n_o(csn2),
        .cs_chg_o(chg2), .sclk_o(sclk2), .mosi_o(mosi2), .miso_i(miso));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd0(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = rdata0;
    endtask

    task automatic rd2(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = rdata2;
    endtask

    task automatic poll(output int cyc);
        logic [31:0] v;
        cyc = 0;
        for (int k = 0; k < 5000; k++) begin
            rd0(A_CTRL, v);
            if (!v[C_START]) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, pat, spat, expi, sent, exps;
        logic [63:0] m;
        int cyc, nb, idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd0(3'(a), v); chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq0}, 32'h0);
        chk("R1 sclk", {31'b0, sclk0}, 32'h0);
        chk("R1 cs_n", {29'b0, csn0}, 32'h7);

        // R13 device request sets flag; R3 masked
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd0(A_STAT, v); chk("R13 dev flag", v & 32'h3, 32'h1);
        chk("R3 masked irq", {31'b0, irq0}, 32'h0);
        wr(A_STAT, 32'h1 << S_DEVM);
        chk("R3 enabled irq", {31'b0, irq0}, 32'h1);
        rd0(A_STAT, v); chk("R2 zero keeps flag", v & 32'h3, 32'h3);
        wr(A_STAT, (32'h1 << S_DEVM) | (32'h1 << S_DEVF));
        rd0(A_STAT, v); chk("R2 w1c", v & 32'h3, 32'h2);
        chk("R3 irq drop", {31'b0, irq0}, 32'h0);
        // R2 set wins
        @(negedge clk);
        dev_irq = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT;
        reg_wdata = (32'h1 << S_DEVM) | (32'h1 << S_DEVF);
        @(negedge clk);
        dev_irq = 1'b0; reg_wr = 1'b0;
        rd0(A_STAT, v); chk("R2 set beats clear", v & 32'h3, 32'h3);
        wr(A_STAT, 32'h1 << S_DEVF);

        // R4 attach flag per channel
        @(negedge clk); pres = 1'b1;
        @(negedge clk); pres = 1'b0;
        rd0(A_STAT, v); chk("R4 ch0 attach", (v >> S_EXTF) & 32'h1, 32'h1);
        rd2(A_STAT, v); chk("R4 ch2 attach", (v >> S_EXTF) & 32'h1, 32'h0);
        wr(A_STAT, 32'h1 << S_EXTM);
        chk("R4 ch0 irq", {31'b0, irq0}, 32'h1);
        chk("R4 ch2 irq", {31'b0, irq2}, 32'h0);
        rd2(A_STAT, v); chk("R4 ch2 bits", v & 32'h30, 32'h0);
        wr(A_STAT, 32'h1 << S_EXTF);

        // R5 boot-memory disable
        wr(A_STAT, 32'h1 << S_ROM);
        chk("R5 ch0 out", {31'b0, rom0}, 32'h1);
        chk("R5 ch2 out", {31'b0, rom2}, 32'h0);
        rd0(A_STAT, v); chk("R5 ch0 read", (v >> S_ROM) & 32'h1, 32'h1);
        rd2(A_STAT, v); chk("R5 ch2 read", (v >> S_ROM) & 32'h1, 32'h0);
        wr(A_STAT, 32'h0);

        // R6 device select
        wr(A_STAT, 32'h2 << S_CS);
        chk("R6 notify", {29'b0, chg0}, 32'h2);
        chk("R6 cs_n", {29'b0, csn0}, 32'h5);
        @(negedge clk);
        chk("R6 notify pulse", {29'b0, chg0}, 32'h0);
        wr(A_STAT, 32'h4 << S_CS);
        chk("R6 notify both", {29'b0, chg0}, 32'h6);
        wr(A_STAT, (32'h3 << S_CS) | (32'h1 << S_CLK));
        chk("R6 bad no notify", {29'b0, chg0}, 32'h0);
        chk("R6 bad keeps", {29'b0, csn0}, 32'h3);
        rd0(A_STAT, v); chk("R6 other fields", (v >> S_CLK) & 32'h7, 32'h1);

        // R11 block words
        wr(A_DADR, 32'hFFFF_FFFF);
        rd0(A_DADR, v); chk("R11 addr", v, 32'hFFFF_FFE0);
        wr(A_DLEN, 32'h1234_567F);
        rd0(A_DLEN, v); chk("R11 len", v, 32'h1234_5660);

        // R10 block mode
        wr(A_STAT, (32'h4 << S_CS) | (32'h1 << S_TCF));
        wr(A_CTRL, 32'h1 | 32'h2 | (32'(DIR_WR) << C_DIR));
        poll(cyc); chk("R10 block done cycles", 32'(cyc), 32'd1);
        rd0(A_STAT, v); chk("R10 block flag", (v >> S_TCF) & 32'h1, 32'h1);
        wr(A_STAT, (32'h4 << S_CS) | (32'h1 << S_TCF));
        wr(A_CTRL, 32'h1 | 32'h2 | (32'(DIR_XCHG) << C_DIR));
        rd0(A_CTRL, v); chk("R10 block duplex rejected", v & 32'h1, 32'h0);
        wr(A_CTRL, 32'h1 | (32'(DIR_RSVD) << C_DIR));
        rd0(A_CTRL, v); chk("R10 reserved rejected", v & 32'h1, 32'h0);
        @(negedge clk);
        rd0(A_STAT, v); chk("R10 no flag", (v >> S_TCF) & 32'h1, 32'h0);

        // R7 R8 R9 immediate sweep
        idx = 0;
        for (int c = 0; c < 2; c++) begin
            for (int d = 0; d < 3; d++) begin
                for (int l = 0; l < 4; l++) begin
                    pat  = 32'h1234_5678 ^ (32'(idx) * 32'h9E37_79B9);
                    spat = 32'hA5C3_0F96 + (32'(idx) * 32'h0101_0101);
                    idx++;
                    nb = 8 * (l + 1);
                    wr(A_STAT, (32'(c) << S_CLK) | (32'h4 << S_CS) | (32'h1 << S_TCF));
                    wr(A_IMM, pat);
                    s_tx = spat; s_rx = '0;
                    wr(A_CTRL, 32'h1 | (32'(d) << C_DIR) | (32'(l) << C_LEN));
                    poll(cyc);
                    chk("R8 duration", 32'(cyc), 32'(16 * (l + 1) << c));
                    m = (64'h1 << nb) - 64'h1;
                    sent = s_rx & m[31:0];
                    exps = (d == 0) ? 32'h0 : 32'(pat >> (32 - nb));
                    chk("R9 sent bits", sent, exps);
                    if (d == 1) expi = pat;
                    else expi = ((spat >> (32 - nb)) << (32 - nb)) |
                                (pat & ~(32'hFFFF_FFFF << (32 - nb)));
                    rd0(A_IMM, v); chk("R9 immediate word", v, expi);
                    rd0(A_STAT, v); chk("R7 done flag", (v >> S_TCF) & 32'h1, 32'h1);
                    rd0(A_CTRL, v);
                    chk("R7 command", v, (32'(d) << C_DIR) | (32'(l) << C_LEN));
                end
            end
        end

        // R12 writes while busy
        wr(A_STAT, (32'h1 << S_CLK) | (32'h4 << S_CS) | (32'h1 << S_TCF));
        wr(A_IMM, 32'hCAFE_F00D);
        wr(A_CTRL, 32'h1 | (32'(DIR_WR) << C_DIR) | (32'h3 << C_LEN));
        wr(A_IMM, 32'h0);
        wr(A_CTRL, 32'h1 | (32'(DIR_RD) << C_DIR));
        poll(cyc);
        rd0(A_IMM, v); chk("R12 immediate held", v, 32'hCAFE_F00D);
        rd0(A_CTRL, v);
        chk("R12 command held", v, (32'(DIR_WR) << C_DIR) | (32'h3 << C_LEN));

        summary();
    end
endmodule